// File: doc/BRIEF.md
# LFSR Stream Message Scrambler

This engine scrambles a short text message held in a byte-wide single-port memory and writes a fixed 64-byte scrambled frame back into the same memory. The message is stored from address 0 upward as offset characters, where a space is held as 0x00. Three setting bytes sit just below the output area: the number of leading spaces, the feedback tap mask, and the starting state of a 7-bit shift register.

After a start request, the engine reads the three settings. It then walks 64 frame positions. At each position it builds a frame byte: 0x00 inside the leading run of spaces, otherwise the message byte that belongs there. It XORs that byte with the current shift-register state, clears the top bit and stores the result. The shift register then advances one step. Reads are combinational and every write lands on a rising clock edge. A done flag reports that the whole frame has been written.

Top module: `lfsr_msg_scrambler`

## Requirements
- R1: Reset (rst_n low) immediately forces done and mem_we low and returns the engine to idle. Once reset is released, no write happens until a start request has been made and withdrawn.
- R2: The keystream register is loaded from the low 7 bits of the byte at address 63 and advances once per frame position as next = {state[5:0], XOR-reduction of (state AND mask)}. The mask is the low 7 bits of the byte at address 62.
- R3: The leading-space count is the full byte read from address 61. The settings are read again on every run.
- R4: Frame position p (0..63) holds 0x00 when p is below the leading-space count. Otherwise it holds the memory byte at address p minus that count, and that byte is read only when the address lies in 0..60. Outside that window the position holds 0x00, so bytes at addresses 61..63 never enter the frame.
- R5: Output byte p equals (frame[p] XOR {0, keystream[p]}) with bit 7 forced to 0, where keystream[0] is the loaded state.
- R6: Output byte p is written to address 64+p. Exactly 64 writes occur per run, in rising address order, and all of them fall in 64..127.
- R7: While start is high the engine performs no writes and done is low. Work begins on the first rising edge at which start is low, and done is high after exactly 132 rising edges counted from that edge.
- R8: done stays high until the next start request or reset. A start request clears it one edge later.
- R9: A start request raised in the middle of a run abandons that run. When start falls again, a fresh run starts from the settings then present in memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| start | input | 1 | Start request; the run begins once it falls |
| done | output | 1 | High once all 64 output bytes are written |
| mem_addr | output | 8 | Memory address for the current read or write |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Combinational read data for mem_addr |

## Verification
The hardest case to reach from the ports is the read window at the tail of the frame. It only matters when the leading-space count is so small that a position's message index would reach the setting bytes at addresses 61..63. The bench drives a run with a zero leading-space count, non-zero setting bytes and a full message. It then checks that the last three output bytes carry pure keystream. Runs that are interrupted or restarted mid-frame by a start pulse or a reset pulse come next: their results can only be seen through done, the write activity and the rewritten output area.

// File: rtl/scr_pkg.sv
package scr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_PRE,
    ST_TAP,
    ST_SEED,
    ST_FETCH,
    ST_STORE,
    ST_DONE
  } scr_state_e;

endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [LW-1:0] seed,
  input  logic [LW-1:0] taps,
  output logic [LW-1:0] state_q
);

  logic [LW-1:0] state_d;
  logic          state_en;

  assign state_en = load | step;

  always_comb begin
    if (load) state_d = seed;
    else      state_d = {state_q[LW-2:0], ^(state_q & taps)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (state_q[LW-1:1] == $past(state_q[LW-2:0]))); // R2

endmodule

// File: rtl/scr_frame_addr.sv
module scr_frame_addr #(
  parameter int DW        = 8,
  parameter int AW        = 8,
  parameter int POS_W     = 6,
  parameter int MSG_LIMIT = 60
) (
  input  logic [POS_W-1:0] pos,
  input  logic [DW-1:0]    pre_len,
  output logic             msg_hit,
  output logic [AW-1:0]    msg_addr
);

  localparam int DIFF_W = DW + 1;

  logic [DIFF_W-1:0] diff;

  always_comb begin
    diff     = DIFF_W'(pos) - DIFF_W'(pre_len);
    msg_hit  = !diff[DIFF_W-1] && (diff[DW-1:0] <= DW'(MSG_LIMIT));
    msg_addr = AW'(diff[DW-1:0]);
  end

endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int POS_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output scr_state_e       state_q,
  output logic [POS_W-1:0] pos_q
);

  scr_state_e       state_d;
  logic [POS_W-1:0] pos_d;
  logic             pos_en;
  logic             pos_last;

  assign pos_last = (pos_q == POS_W'(FRAME_LEN - 1));

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_HOLD;
    end else begin
      case (state_q)
        ST_IDLE:  state_d = ST_IDLE;
        ST_HOLD:  state_d = ST_PRE;
        ST_PRE:   state_d = ST_TAP;
        ST_TAP:   state_d = ST_SEED;
        ST_SEED:  state_d = ST_FETCH;
        ST_FETCH: state_d = ST_STORE;
        ST_STORE: state_d = pos_last ? ST_DONE : ST_FETCH;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pos_en = (state_q == ST_SEED) || (state_q == ST_STORE);
    pos_d  = (state_q == ST_SEED) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  AST_STORE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STORE) |-> ($past(state_q) == ST_FETCH)); // R4

  AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STORE && !pos_last) |=> (pos_q == $past(pos_q) + 1'b1)); // R6

endmodule

// File: rtl/lfsr_msg_scrambler.sv
module lfsr_msg_scrambler
  import scr_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 8,
  parameter int LW        = 7,
  parameter int FRAME_LEN = 64,
  parameter int PRE_ADDR  = 61,
  parameter int TAP_ADDR  = 62,
  parameter int SEED_ADDR = 63,
  parameter int OUT_BASE  = 64,
  parameter int MSG_LIMIT = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int POS_W = $clog2(FRAME_LEN);
  localparam logic [AW-1:0] PRE_A  = AW'(PRE_ADDR);
  localparam logic [AW-1:0] TAP_A  = AW'(TAP_ADDR);
  localparam logic [AW-1:0] SEED_A = AW'(SEED_ADDR);
  localparam logic [AW-1:0] OUT_A  = AW'(OUT_BASE);
  localparam logic [DW-1:0] LOW_MASK = {1'b0, {(DW-1){1'b1}}};

  scr_state_e       state;
  logic [POS_W-1:0] pos;
  logic [LW-1:0]    ks_state;
  logic             msg_hit;
  logic [AW-1:0]    msg_addr;

  logic [DW-1:0]    pre_q,   pre_d;
  logic [LW-1:0]    taps_q,  taps_d;
  logic [DW-1:0]    frame_q, frame_d;
  logic             pre_en,  taps_en, frame_en;

  scr_ctrl #(
    .FRAME_LEN (FRAME_LEN),
    .POS_W     (POS_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .state_q (state),
    .pos_q   (pos)
  );

  scr_frame_addr #(
    .DW        (DW),
    .AW        (AW),
    .POS_W     (POS_W),
    .MSG_LIMIT (MSG_LIMIT)
  ) u_frame_addr (
    .pos      (pos),
    .pre_len  (pre_q),
    .msg_hit  (msg_hit),
    .msg_addr (msg_addr)
  );

  scr_lfsr #(
    .LW (LW)
  ) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (state == ST_SEED),
    .step    (state == ST_STORE),
    .seed    (mem_rdata[LW-1:0]),
    .taps    (taps_q),
    .state_q (ks_state)
  );

  // setting and frame capture: next values and enables
  always_comb begin
    pre_en   = (state == ST_PRE);
    taps_en  = (state == ST_TAP);
    frame_en = (state == ST_FETCH);
    pre_d    = mem_rdata;
    taps_d   = mem_rdata[LW-1:0];
    frame_d  = msg_hit ? mem_rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      taps_q  <= '0;
      frame_q <= '0;
    end else begin
      if (pre_en)   pre_q   <= pre_d;
      if (taps_en)  taps_q  <= taps_d;
      if (frame_en) frame_q <= frame_d;
    end
  end

  // memory port
  always_comb begin
    mem_we    = (state == ST_STORE);
    mem_wdata = (frame_q ^ DW'(ks_state)) & LOW_MASK;
    case (state)
      ST_PRE:   mem_addr = PRE_A;
      ST_TAP:   mem_addr = TAP_A;
      ST_SEED:  mem_addr = SEED_A;
      ST_FETCH: mem_addr = msg_hit ? msg_addr : '0;
      ST_STORE: mem_addr = OUT_A + AW'(pos);
      default:  mem_addr = '0;
    endcase
  end

  assign done = (state == ST_DONE);

  AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= OUT_A && mem_addr <= OUT_A + AW'(FRAME_LEN - 1))); // R6

  AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_wdata[DW-1]); // R5

  AST_QUIET_WHILE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!mem_we && !done)); // R7

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R8

endmodule

// File: tb/tb_lfsr_msg_scrambler.sv
module tb_lfsr_msg_scrambler;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // {pre, taps, seed, msg_len, char_base}
  localparam logic [39:0] VECS [NVEC] = '{
    {8'd10, 8'h60, 8'h01, 8'd41, 8'h2D},
    {8'd26, 8'h48, 8'h7F, 8'd54, 8'h01},
    {8'd17, 8'h78, 8'h55, 8'd20, 8'h30},
    {8'd12, 8'h72, 8'h2A, 8'd54, 8'h40},
    {8'd20, 8'h6A, 8'h13, 8'd1,  8'h7F},
    {8'd15, 8'h7B, 8'h64, 8'd0,  8'h00}
  };

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       done;
  logic [7:0] mem_addr;
  logic       mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;

  logic [7:0] mem [256];
  logic [7:0] img [61];
  logic [7:0] exp_out [64];
  int wr_cnt, bad_cnt, order_err, last_wr;
  int n_checks, n_fail;

  lfsr_msg_scrambler dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (mem_addr < 8'd64 || mem_addr > 8'd127) bad_cnt++;
      if (int'(mem_addr) != last_wr + 1) order_err++;
      last_wr = int'(mem_addr);
      wr_cnt++;
    end
  end

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_counts();
    wr_cnt = 0; bad_cnt = 0; order_err = 0; last_wr = 63;
  endtask

  task automatic load_mem(input logic [7:0] pre, input logic [7:0] taps,
                          input logic [7:0] seed, input int len, input logic [7:0] base);
    for (int a = 0; a < 61; a++) begin
      mem[a] = (a < len) ? ((base + 8'(a * 7)) & 8'h7F) : 8'h00;
      img[a] = mem[a];
    end
    mem[61] = pre;
    mem[62] = taps;
    mem[63] = seed;
    for (int a = 64; a < 256; a++) mem[a] = 8'hEE;
    build_expect(pre, taps, seed);
  endtask

  task automatic build_expect(input logic [7:0] pre, input logic [7:0] taps, input logic [7:0] seed);
    logic [6:0] ks;
    logic [7:0] fr;
    int idx;
    ks = seed[6:0];
    for (int p = 0; p < 64; p++) begin
      idx = p - int'(pre);
      fr  = (idx >= 0 && idx <= 60) ? img[idx] : 8'h00;
      exp_out[p] = (fr ^ {1'b0, ks}) & 8'h7F;
      ks = {ks[5:0], ^(ks & taps[6:0])};
    end
  endtask

  // raise start for hold cycles, drop it, wait for done, check frame
  task automatic run_frame(input int hold, input string tag);
    int cyc;
    int mism;
    @(negedge clk);
    start = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(!mem_we && !done, "R7 quiet while start high", int'(mem_we), 0);
    end
    clear_counts();
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 132, "R7 done latency", cyc, 132);
    check(wr_cnt == 64, "R6 write count", wr_cnt, 64);
    check(bad_cnt == 0 && order_err == 0, "R6 write addresses", bad_cnt + order_err, 0);
    mism = 0;
    for (int p = 0; p < 64; p++) begin
      if (mem[64 + p] !== exp_out[p]) begin
        mism++;
        $display("FAIL R5 %s byte %0d actual=%h expected=%h", tag, p, mem[64 + p], exp_out[p]);
      end
    end
    n_checks++;
    if (mism != 0) n_fail++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0;
    clear_counts();
    rst_n = 1'b0;
    start = 1'b0;
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    check(!done && !mem_we, "R1 reset state", int'(done) + int'(mem_we), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(wr_cnt == 0 && !done, "R1 idle after reset", wr_cnt, 0);

    // table of vectors: R2 R3 R4 R5 across tap masks, seeds, lengths
    for (int v = 0; v < NVEC; v++) begin
      load_mem(VECS[v][39:32], VECS[v][31:24], VECS[v][23:16],
               int'(VECS[v][15:8]), VECS[v][7:0]);
      run_frame(2 + v, "vector R2 R3");
    end

    // R4: zero leading spaces, full message; positions 61..63 must be pure keystream
    load_mem(8'd0, 8'h5C, 8'h03, 54, 8'h11);
    run_frame(3, "R4 zero preamble");
    // R4: leading run longer than the message window tail drops overflow
    load_mem(8'd40, 8'h69, 8'h11, 54, 8'h22);
    run_frame(2, "R4 late message");
    // R4: leading run covers the whole frame
    load_mem(8'd70, 8'h7E, 8'h05, 54, 8'h33);
    run_frame(2, "R4 all spaces");

    // R8: done stays high with start low, no stray writes
    clear_counts();
    repeat (20) @(negedge clk);
    check(done && wr_cnt == 0, "R8 done sticky", int'(done), 1);
    start = 1'b1;
    @(negedge clk);
    check(!done, "R8 start clears done", int'(done), 0);
    start = 1'b0;
    repeat (140) @(negedge clk);

    // R9: restart mid-run with new settings
    load_mem(8'd10, 8'h60, 8'h01, 41, 8'h2D);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    load_mem(8'd13, 8'h48, 8'h3C, 30, 8'h05);
    run_frame(2, "R9 restart");

    // R1: reset in the middle of a run
    load_mem(8'd11, 8'h72, 8'h09, 50, 8'h44);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!done && !mem_we, "R1 async reset mid-run", int'(mem_we), 0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_counts();
    repeat (30) @(negedge clk);
    check(wr_cnt == 0 && !done, "R1 idle after mid-run reset", wr_cnt, 0);
    run_frame(2, "R1 run after reset");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule